// File: doc/BRIEF.md
# Scrambled-Address Byte Register Bridge with Read Lock

This block sits between a host register port and the byte-wide register file of a display controller. The host does not see the controller's registers at their native 16-bit addresses. Each register is instead reached at an offset whose bits are a fixed interleaving of the native address bits. The bridge undoes that interleaving on every request before it decodes the register. A small byte array stands in for the controller. It is indexed by the low bits of the native address, so every native address maps onto one of its entries and several addresses share each entry.

A second window above the 64 KiB controller window holds one 32-bit lock register. It is write-only and responds to two magic words. One opens the controller window for reads and the other closes it again. The block leaves reset closed. While closed, reads of the controller window return zero, but writes still land. The controller window accepts only single-byte accesses. Any wider access gets an error response and changes nothing.

The request port is a simple valid/ready port. It takes a 17-bit byte address, a size code, a write flag and 32 bits of write data. Every accepted request produces exactly one response, one cycle later.

Top module: `scram_reg_bridge`

## Requirements
- R1: After reset the bridge is locked, rsp_valid is 0 and every byte of the register array reads as 0x00 once unlocked; req_ready is 1 whenever reset is low.
- R2: Within the controller window (req_addr[16]=0), host bits 15..8 carry native bits 1,3,5,7,9,11,13,15 in that order, host bits 7..1 carry native bits 14,12,10,8,6,4,2 in that order, and host bit 0 is native bit 0; native 0x100D is reached at host 0x4043.
- R3: The host-to-native mapping is a bijection on 16 bits, and its inverse maps each native address back to the host offset it came from.
- R4: A byte write (req_size=2'b00) to the controller window stores req_wdata[7:0] in array entry native[5:0] (default depth 64); every native address with the same low six bits reaches the same entry.
- R5: A request accepted at one rising edge yields rsp_valid=1 for exactly the following cycle; an unlocked byte read returns the stored byte in rsp_rdata[7:0] with the upper 24 bits zero and rsp_err=0.
- R6: While locked, a byte read of the controller window returns 0x00 with rsp_err=0 and leaves the stored contents unchanged.
- R7: A word write (req_size=2'b10) of 0x54524545 to side offset 0x10010 unlocks reads; a word write of 0x57415452 there locks them.
- R8: A write of any other value to 0x10010, or a write there with a size other than word, leaves the lock state unchanged.
- R9: Any controller-window access with req_size not equal to 2'b00 responds with rsp_err=1 and rsp_rdata=0 and does not write the array.
- R10: Reads of 0x10010 return zero with rsp_err=0; other side-window offsets read as zero, ignore writes and never raise an error.
- R11: Byte writes to the controller window take effect while the bridge is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address; bit 16 selects the side window |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access-size error |

## Verification
The embedded properties watch, on every cycle, the one-cycle response timing, the error flag on non-byte window accesses together with the absence of an array write in that case, zero read data while locked, and how the lock state reacts to magic and non-magic writes. Only the bench's scenarios can show that the bit interleaving is right and invertible over all 65536 addresses, that entries alias through the low native bits, and that stored data survives locked reads and rejected accesses. They can also show the worked 0x100D/0x4043 case and that a fresh reset clears both the array and the lock.

// File: rtl/scram_bridge_pkg.sv
package scram_bridge_pkg;

    localparam int NATIVE_AW = 16;
    localparam int HOST_AW   = 17;
    localparam int DATA_W    = 32;

    localparam logic [HOST_AW-1:0] LOCK_OFFSET = 17'h10010;
    localparam logic [DATA_W-1:0]  KEY_OPEN    = 32'h5452_4545;
    localparam logic [DATA_W-1:0]  KEY_CLOSE   = 32'h5741_5452;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_e;

    // Decoded view of one accepted request
    typedef struct packed {
        logic                 fire;
        logic                 wr;
        logic                 win;     // controller window
        logic                 key;     // lock register offset
        logic                 narrow;  // byte sized
        logic                 wide32;  // word sized
        logic [NATIVE_AW-1:0] native;
    } req_dec_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    // Native bit index carried by host bit h of the controller window.
    function automatic int native_bit_of(input int h);
        if (h == 0)
            return 0;
        else if (h <= 7)
            return 2 * h;
        else
            return 31 - 2 * h;
    endfunction

endpackage

// File: rtl/addr_permute.sv
module addr_permute
    import scram_bridge_pkg::*;
#(
    parameter bit INVERSE = 1'b0   // 0: host -> native, 1: native -> host
) (
    input  logic [NATIVE_AW-1:0] in_addr,
    output logic [NATIVE_AW-1:0] out_addr
);

    for (genvar h = 0; h < NATIVE_AW; h++) begin : g_bit
        localparam int NB = native_bit_of(h);
        if (INVERSE) begin : g_inv
            assign out_addr[h] = in_addr[NB];
        end else begin : g_fwd
            assign out_addr[NB] = in_addr[h];
        end
    end

endmodule

// File: rtl/gate_lock.sv
module gate_lock
    import scram_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_data,
    output logic              open
);

    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (key_we) begin
            if (key_data == KEY_OPEN)
                state_d = GATE_OPEN;
            else if (key_data == KEY_CLOSE)
                state_d = GATE_CLOSED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= GATE_CLOSED;
        else
            state_q <= state_d;
    end

    assign open = (state_q == GATE_OPEN);

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        key_we && key_data == KEY_OPEN |=> open); // R7

    AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        key_we && key_data == KEY_CLOSE |=> !open); // R7

    AST_KEY_OTHER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(key_we && (key_data == KEY_OPEN || key_data == KEY_CLOSE))
        |=> open == $past(open)); // R8

endmodule

// File: rtl/byte_regfile.sv
module byte_regfile
    import scram_bridge_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [NATIVE_AW-1:0] addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    assign idx       = addr[IDX_W-1:0];
    assign unused_hi = ^addr[NATIVE_AW-1:IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'h00;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(idx)] == $past(wdata)); // R4

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !we |=> mem[$past(idx)] == $past(rdata)); // R6

endmodule

// File: rtl/scram_reg_bridge.sv
module scram_reg_bridge
    import scram_bridge_pkg::*;
#(
    parameter int REG_DEPTH = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [HOST_AW-1:0]  req_addr,
    input  logic [1:0]          req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err
);

    req_dec_t             dec;
    rsp_t                 rsp_q;
    logic [NATIVE_AW-1:0] native_addr;
    logic                 gate_open;
    logic                 rf_we;
    logic                 key_we;
    logic [7:0]           rf_rdata;

    assign req_ready = !rst;

    addr_permute #(.INVERSE(1'b0)) u_unscramble (
        .in_addr  (req_addr[NATIVE_AW-1:0]),
        .out_addr (native_addr)
    );

    always_comb begin
        dec.fire   = req_valid && req_ready;
        dec.wr     = req_write;
        dec.win    = !req_addr[HOST_AW-1];
        dec.key    = (req_addr == LOCK_OFFSET);
        dec.narrow = (acc_size_e'(req_size) == SZ_BYTE);
        dec.wide32 = (acc_size_e'(req_size) == SZ_WORD);
        dec.native = native_addr;
    end

    assign rf_we  = dec.fire && dec.wr && dec.win && dec.narrow;
    assign key_we = dec.fire && dec.wr && dec.key && dec.wide32;

    gate_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_we),
        .key_data (req_wdata),
        .open     (gate_open)
    );

    byte_regfile #(.DEPTH(REG_DEPTH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .addr  (dec.native),
        .wdata (req_wdata[7:0]),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= dec.fire;
            if (dec.fire) begin
                rsp_q.err  <= dec.win && !dec.narrow;
                rsp_q.data <= (!dec.wr && dec.win && dec.narrow && gate_open)
                              ? {24'h0, rf_rdata} : '0;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
    assign rsp_err   = rsp_q.err;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dec.fire |=> rsp_valid); // R5

    AST_RSP_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (rst)
        !dec.fire |=> !rsp_valid); // R5

    AST_ERR_NON_BYTE: assert property (@(posedge clk) disable iff (rst)
        dec.fire && dec.win && !dec.narrow |=> rsp_err && rsp_rdata == '0); // R9

    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        dec.fire && dec.win && !dec.narrow |-> !rf_we); // R9

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        dec.fire && !dec.wr && dec.win && !gate_open |=> rsp_rdata == '0); // R6

    AST_SIDE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        dec.fire && !dec.win |=> !rsp_err && rsp_rdata == '0); // R10

endmodule

// File: tb/tb_scram_reg_bridge.sv
module tb_scram_reg_bridge;
    import scram_bridge_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [16:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scram_reg_bridge dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    // Stand-alone permutation instances for the full address sweep
    logic [15:0] p_host, p_nat, q_nat, q_host;
    addr_permute #(.INVERSE(1'b0)) u_fwd (.in_addr(p_host), .out_addr(p_nat));
    addr_permute #(.INVERSE(1'b1)) u_inv (.in_addr(q_nat),  .out_addr(q_host));

    // Reference: native bit carried by host bit h, taken from the R2 lists
    localparam int NAT_OF_HOST [16] =
        '{0, 2, 4, 6, 8, 10, 12, 14, 15, 13, 11, 9, 7, 5, 3, 1};

    function automatic logic [15:0] ref_native(input logic [15:0] h);
        logic [15:0] n = '0;
        for (int b = 0; b < 16; b++) n[NAT_OF_HOST[b]] = h[b];
        return n;
    endfunction

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 17'h04043, 2'b00, 32'h0000_00A5, 32'h0, 1'b0, 8'd11}, // R11 write while locked
        '{1'b0, 17'h04043, 2'b00, 32'h0,         32'h0, 1'b0, 8'd6 }, // R6 locked read
        '{1'b1, 17'h10010, 2'b10, 32'h5452_4545, 32'h0, 1'b0, 8'd7 }, // R7 unlock
        '{1'b0, 17'h04043, 2'b00, 32'h0,         32'hA5, 1'b0, 8'd11}, // R11 write kept
        '{1'b0, 17'h04003, 2'b00, 32'h0,         32'hA5, 1'b0, 8'd4 }, // R4 alias native 0x000D
        '{1'b1, 17'h00001, 2'b01, 32'h0000_1234, 32'h0, 1'b1, 8'd9 }, // R9 half write
        '{1'b0, 17'h00001, 2'b00, 32'h0,         32'h0, 1'b0, 8'd9 }, // R9 nothing written
        '{1'b1, 17'h10010, 2'b10, 32'h1234_5678, 32'h0, 1'b0, 8'd8 }, // R8 other value
        '{1'b0, 17'h04043, 2'b00, 32'h0,         32'hA5, 1'b0, 8'd8 }, // R8 still open
        '{1'b0, 17'h10010, 2'b10, 32'h0,         32'h0, 1'b0, 8'd10}, // R10 key reads zero
        '{1'b1, 17'h10010, 2'b10, 32'h5741_5452, 32'h0, 1'b0, 8'd7 }, // R7 lock
        '{1'b0, 17'h04043, 2'b00, 32'h0,         32'h0, 1'b0, 8'd7 }, // R7 locked again
        '{1'b1, 17'h10010, 2'b01, 32'h5452_4545, 32'h0, 1'b0, 8'd8 }, // R8 non-word key
        '{1'b0, 17'h04043, 2'b00, 32'h0,         32'h0, 1'b0, 8'd8 }, // R8 stays locked
        '{1'b1, 17'h08000, 2'b00, 32'h0000_003C, 32'h0, 1'b0, 8'd2 }, // R2 host b15 -> native b1
        '{1'b1, 17'h10010, 2'b10, 32'h5452_4545, 32'h0, 1'b0, 8'd7 }, // R7 unlock
        '{1'b0, 17'h08020, 2'b00, 32'h0,         32'h3C, 1'b0, 8'd2 }, // R2 native 0x0402 -> entry 2
        '{1'b0, 17'h04043, 2'b10, 32'h0,         32'h0, 1'b1, 8'd9 }, // R9 word read
        '{1'b1, 17'h1FFFC, 2'b00, 32'h0000_00FF, 32'h0, 1'b0, 8'd10}, // R10 side write
        '{1'b0, 17'h1FFFC, 2'b00, 32'h0,         32'h0, 1'b0, 8'd10}, // R10 side read
        '{1'b0, 17'h00002, 2'b00, 32'h0,         32'h0, 1'b0, 8'd5 }  // R5 native 0x0004 empty
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge; sample the response one cycle on.
    task automatic do_op(input logic wr, input logic [16:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic        er, vl;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = '0; req_wdata = '0;
        p_host = '0; q_nat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, {30'b0, rsp_valid, req_ready}, 32'h1, "reset valid/ready");  // R1

        // Table walk
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, er, vl);
            check(VEC[i].req, {vl, er, rd[29:0]}, {1'b1, VEC[i].exp_err, VEC[i].exp_data[29:0]},
                  $sformatf("vector %0d", i));
            check(VEC[i].req, {30'b0, rd[31:30]}, {30'b0, VEC[i].exp_data[31:30]},
                  $sformatf("vector %0d top bits", i));
        end

        // R5: response pulses for exactly one cycle
        @(negedge clk);
        check(5, {31'b0, rsp_valid}, 32'h0, "rsp_valid dropped after one cycle");

        // R2 / R3: full sweep of both directions
        begin
            int bad_f = 0, bad_i = 0;
            for (int a = 0; a < 65536; a++) begin
                p_host = a[15:0];
                q_nat  = ref_native(a[15:0]);
                #1;
                if (p_nat !== ref_native(a[15:0])) bad_f++;
                if (q_host !== a[15:0]) bad_i++;
            end
            check(2, bad_f, 0, "forward permutation mismatches");   // R2
            check(3, bad_i, 0, "inverse permutation mismatches");   // R3
        end
        p_host = 16'h4043; #1;
        check(2, {16'h0, p_nat}, 32'h100D, "worked case 0x4043");  // R2

        // R1: reset mid-run clears array and relocks
        do_op(1'b1, 17'h04043, 2'b00, 32'h5A, rd, er, vl);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_op(1'b0, 17'h04043, 2'b00, 32'h0, rd, er, vl);
        check(1, rd, 32'h0, "locked after reset");                  // R1
        do_op(1'b1, 17'h10010, 2'b10, 32'h5452_4545, rd, er, vl);
        do_op(1'b0, 17'h04043, 2'b00, 32'h0, rd, er, vl);
        check(1, rd, 32'h0, "array cleared by reset");              // R1

        // R6: a locked read must not disturb the stored byte
        do_op(1'b1, 17'h00080, 2'b00, 32'h77, rd, er, vl);
        do_op(1'b1, 17'h10010, 2'b10, 32'h5741_5452, rd, er, vl);
        do_op(1'b0, 17'h00080, 2'b00, 32'h0, rd, er, vl);
        check(6, rd, 32'h0, "locked read zero");                    // R6
        do_op(1'b1, 17'h10010, 2'b10, 32'h5452_4545, rd, er, vl);
        do_op(1'b0, 17'h00080, 2'b00, 32'h0, rd, er, vl);
        check(6, rd, 32'h77, "byte intact after locked read");      // R6

        // R9: reserved size also errors without writing
        do_op(1'b1, 17'h00080, 2'b11, 32'h11, rd, er, vl);
        check(9, {31'b0, er}, 32'h1, "reserved size error");        // R9
        do_op(1'b0, 17'h00080, 2'b00, 32'h0, rd, er, vl);
        check(9, rd, 32'h77, "no write on reserved size");          // R9

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule